// File: doc/BRIEF.md
# Encrypt-then-MAC Block Scheduler

This control block drives two external engines, a block cipher and a hash-based MAC, so that a stream of message blocks is first encrypted and the resulting ciphertext is then authenticated. Both engines work on the same block width. Each one starts on a one-cycle start pulse and reports completion with a one-cycle ready pulse, and its result is valid in that ready cycle. The scheduler contains no cipher or hash datapath. It accepts plaintext blocks on a valid/ready input and launches the cipher. It routes every ciphertext block to the hash engine and to its own ciphertext output. After the block flagged as last has been absorbed, it issues one finalisation command to the hash engine. It then presents the tag together with the number of blocks in the message.

Encryption of the next block overlaps with hashing of the current one. With a 31-cycle cipher and an 18-cycle hash, the hash engine idles for 13 cycles of every block, and a new block can enter in the same cycle that the previous ciphertext appears. When the hash engine is the slower of the two, a single ciphertext holding register absorbs the mismatch. Input acceptance then stalls until that register is sure to be empty when the next ciphertext arrives, so blocks are still hashed strictly in order.

Top module: `etm_sched`

## Requirements
- R1: After reset, msg_ready_o is 1 and cipher_start_o, hash_start_o, ct_valid_o and tag_valid_o are all 0.
- R2: A block is accepted in a cycle where msg_valid_i and msg_ready_o are both 1. In that same cycle, cipher_start_o is 1 and cipher_data_o equals msg_data_i. While msg_ready_o is 0, msg_valid_i has no effect: no cipher start occurs and no extra ciphertext appears.
- R3: When the hash engine is free, ct_valid_o is a one-cycle strobe in the cycle cipher_ready_i is 1, and ct_data_o equals cipher_result_i. With a 31-cycle cipher, this is 31 cycles after acceptance.
- R4: Every ciphertext strobe coincides with hash_start_o = 1, hash_final_o = 0 and hash_data_o = ct_data_o.
- R5: If the next block is already waiting, it is accepted in the same cycle as the previous block's cipher_ready_i, so back-to-back blocks are accepted 31 cycles apart.
- R6: cipher_start_o is never 1 while a cipher operation is running, unless cipher_ready_i is 1 in that cycle.
- R7: A new cipher start is only issued if the previous ciphertext will have been handed to the hash engine by the time the new ciphertext arrives. Ciphertext blocks reach the hash engine in acceptance order and none is lost.
- R8: Once the last block has been absorbed and the hash engine is free, a finalisation command is issued: hash_start_o = 1, hash_final_o = 1, hash_data_o = 0. With an 18-cycle hash, this falls in the same cycle as the last absorb's ready.
- R9: tag_valid_o is a one-cycle strobe, one cycle after the final hash ready. tag_o equals the hash result of that finalisation. With 31/18 latencies, this is 68 cycles after the last block was accepted.
- R10: msg_ready_o is 0 from the cycle after the last block is accepted until the tag strobe. It is 1 again in the tag cycle.
- R11: hash_start_o is never 1 while a hash operation is running, unless hash_ready_i is 1 in that cycle.
- R12: tag_len_o equals the number of blocks accepted for that message, from the tag strobe onward. A single-block message reports 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Plaintext block offered |
| msg_ready_o | output | 1 | Scheduler can accept a block |
| msg_data_i | input | BLK_W | Plaintext block |
| msg_last_i | input | 1 | Offered block ends the message |
| cipher_start_o | output | 1 | Start pulse to the cipher engine |
| cipher_data_o | output | BLK_W | Plaintext to the cipher engine |
| cipher_ready_i | input | 1 | Cipher done pulse |
| cipher_result_i | input | BLK_W | Ciphertext, valid with cipher_ready_i |
| hash_start_o | output | 1 | Start pulse to the hash engine |
| hash_final_o | output | 1 | Start is the finalisation step |
| hash_data_o | output | BLK_W | Block to absorb (zero on finalisation) |
| hash_ready_i | input | 1 | Hash done pulse |
| hash_result_i | input | BLK_W | Hash result, valid with hash_ready_i |
| ct_valid_o | output | 1 | Ciphertext strobe |
| ct_data_o | output | BLK_W | Ciphertext block |
| tag_valid_o | output | 1 | Tag strobe |
| tag_o | output | BLK_W | Authentication tag |
| tag_len_o | output | LEN_W | Number of blocks in the tagged message |

## Verification
Every result sits at a fixed distance from the acceptance cycle of the block that causes it, given the 31-cycle and 18-cycle stand-in engines. The ciphertext strobe and its hash absorb start come 31 cycles after acceptance. The next back-to-back acceptance falls in that same cycle. The finalisation start comes 49 cycles after the last acceptance, and the tag strobe comes 68 cycles after it. The bench records the cycle index of each acceptance, strobe and start at the falling edge, and compares the differences against these exact offsets. It does not wait for events with open-ended windows. Data checks compare against the stand-in cipher transform and a bench-side fold of the expected ciphertext into the tag.

// File: rtl/etm_pkg.sv
package etm_pkg;
  typedef enum logic [1:0] {
    HOP_NONE   = 2'd0,
    HOP_ABSORB = 2'd1,
    HOP_FINAL  = 2'd2
  } hash_op_e;
endpackage

// File: rtl/etm_in_ctl.sv
module etm_in_ctl #(
  parameter int BLK_W = 64,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  input  logic [BLK_W-1:0] msg_data_i,
  input  logic             msg_last_i,
  input  logic             buf_ok_i,
  input  logic             absorb_i,
  input  logic             tag_done_i,
  input  logic             cipher_ready_i,
  output logic             msg_ready_o,
  output logic             cipher_start_o,
  output logic [BLK_W-1:0] cipher_data_o,
  output logic             last_seen_o,
  output logic             drained_o,
  output logic [LEN_W-1:0] tag_len_o
);
  localparam int OUT_W = 2;

  logic             cbusy_q, last_q;
  logic [OUT_W-1:0] out_q;
  logic [LEN_W-1:0] len_q, tag_len_q;
  logic             cipher_free, accept;

  assign cipher_free    = !cbusy_q || cipher_ready_i;
  assign msg_ready_o    = cipher_free && buf_ok_i && !last_q;
  assign accept         = msg_valid_i && msg_ready_o;
  assign cipher_start_o = accept;
  assign cipher_data_o  = msg_data_i;
  assign last_seen_o    = last_q;
  assign drained_o      = (out_q == '0);
  assign tag_len_o      = tag_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cbusy_q   <= 1'b0;
      last_q    <= 1'b0;
      out_q     <= '0;
      len_q     <= '0;
      tag_len_q <= '0;
    end else begin
      if (accept)              cbusy_q <= 1'b1;
      else if (cipher_ready_i) cbusy_q <= 1'b0;
      // blocks accepted but not yet absorbed by the hash
      out_q <= out_q + OUT_W'(accept) - OUT_W'(absorb_i);
      if (tag_done_i) begin
        last_q    <= 1'b0;
        tag_len_q <= len_q;
        len_q     <= '0;
      end else if (accept) begin
        len_q <= len_q + 1'b1;
        if (msg_last_i) last_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/etm_ct_path.sv
module etm_ct_path #(
  parameter int BLK_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cipher_ready_i,
  input  logic [BLK_W-1:0] cipher_result_i,
  input  logic             hash_free_i,
  output logic             absorb_o,
  output logic [BLK_W-1:0] absorb_data_o,
  output logic             buf_ok_o,
  output logic             pend_o
);
  logic             pend_q;
  logic [BLK_W-1:0] buf_q;
  logic             take_buf, direct, park;

  assign take_buf      = pend_q && hash_free_i;
  assign direct        = !pend_q && cipher_ready_i && hash_free_i;
  assign park          = !pend_q && cipher_ready_i && !hash_free_i;
  assign absorb_o      = take_buf || direct;
  assign absorb_data_o = pend_q ? buf_q : cipher_result_i;
  // holding register must be empty after this edge
  assign buf_ok_o      = pend_q ? take_buf : !park;
  assign pend_o        = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      buf_q  <= '0;
    end else if (park) begin
      pend_q <= 1'b1;
      buf_q  <= cipher_result_i;
    end else if (take_buf) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/etm_hash_ctl.sv
module etm_hash_ctl
  import etm_pkg::*;
#(
  parameter int BLK_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             absorb_i,
  input  logic [BLK_W-1:0] absorb_data_i,
  input  logic             last_seen_i,
  input  logic             drained_i,
  input  logic             hash_ready_i,
  input  logic [BLK_W-1:0] hash_result_i,
  output logic             hash_free_o,
  output logic             hash_start_o,
  output logic             hash_final_o,
  output logic [BLK_W-1:0] hash_data_o,
  output logic             tag_done_o,
  output logic             tag_valid_o,
  output logic [BLK_W-1:0] tag_o
);
  logic             hbusy_q, fin_wait_q, tag_v_q;
  logic [BLK_W-1:0] tag_q;
  hash_op_e         op;

  assign hash_free_o = !hbusy_q || hash_ready_i;

  always_comb begin
    op = HOP_NONE;
    if (absorb_i) op = HOP_ABSORB;
    else if (last_seen_i && drained_i && !fin_wait_q && hash_free_o) op = HOP_FINAL;
  end

  assign hash_start_o = (op != HOP_NONE);
  assign hash_final_o = (op == HOP_FINAL);
  assign hash_data_o  = (op == HOP_ABSORB) ? absorb_data_i : '0;
  assign tag_done_o   = fin_wait_q && hash_ready_i;
  assign tag_valid_o  = tag_v_q;
  assign tag_o        = tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hbusy_q    <= 1'b0;
      fin_wait_q <= 1'b0;
      tag_v_q    <= 1'b0;
      tag_q      <= '0;
    end else begin
      if (hash_start_o)      hbusy_q <= 1'b1;
      else if (hash_ready_i) hbusy_q <= 1'b0;
      if (op == HOP_FINAL)   fin_wait_q <= 1'b1;
      else if (tag_done_o)   fin_wait_q <= 1'b0;
      tag_v_q <= tag_done_o;
      if (tag_done_o) tag_q <= hash_result_i;
    end
  end
endmodule

// File: rtl/etm_sched.sv
module etm_sched #(
  parameter int BLK_W = 64,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  output logic             msg_ready_o,
  input  logic [BLK_W-1:0] msg_data_i,
  input  logic             msg_last_i,
  output logic             cipher_start_o,
  output logic [BLK_W-1:0] cipher_data_o,
  input  logic             cipher_ready_i,
  input  logic [BLK_W-1:0] cipher_result_i,
  output logic             hash_start_o,
  output logic             hash_final_o,
  output logic [BLK_W-1:0] hash_data_o,
  input  logic             hash_ready_i,
  input  logic [BLK_W-1:0] hash_result_i,
  output logic             ct_valid_o,
  output logic [BLK_W-1:0] ct_data_o,
  output logic             tag_valid_o,
  output logic [BLK_W-1:0] tag_o,
  output logic [LEN_W-1:0] tag_len_o
);
  logic             buf_ok, absorb, tag_done, last_seen, drained, hash_free, pend;
  logic [BLK_W-1:0] absorb_data;

  etm_in_ctl #(.BLK_W(BLK_W), .LEN_W(LEN_W)) u_in (
    .clk_i, .rst_ni, .msg_valid_i, .msg_data_i, .msg_last_i,
    .buf_ok_i(buf_ok), .absorb_i(absorb), .tag_done_i(tag_done),
    .cipher_ready_i, .msg_ready_o, .cipher_start_o, .cipher_data_o,
    .last_seen_o(last_seen), .drained_o(drained), .tag_len_o
  );

  etm_ct_path #(.BLK_W(BLK_W)) u_ct (
    .clk_i, .rst_ni, .cipher_ready_i, .cipher_result_i,
    .hash_free_i(hash_free), .absorb_o(absorb), .absorb_data_o(absorb_data),
    .buf_ok_o(buf_ok), .pend_o(pend)
  );

  etm_hash_ctl #(.BLK_W(BLK_W)) u_hash (
    .clk_i, .rst_ni, .absorb_i(absorb), .absorb_data_i(absorb_data),
    .last_seen_i(last_seen), .drained_i(drained), .hash_ready_i, .hash_result_i,
    .hash_free_o(hash_free), .hash_start_o, .hash_final_o, .hash_data_o,
    .tag_done_o(tag_done), .tag_valid_o, .tag_o
  );

  assign ct_valid_o = absorb;
  assign ct_data_o  = absorb_data;
endmodule

// File: rtl/etm_sched_chk.sv
module etm_sched_chk #(
  parameter int BLK_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msg_ready_o,
  input logic             cipher_start_o,
  input logic             cipher_ready_i,
  input logic             hash_start_o,
  input logic             hash_final_o,
  input logic [BLK_W-1:0] hash_data_o,
  input logic             hash_ready_i,
  input logic             ct_valid_o,
  input logic [BLK_W-1:0] ct_data_o,
  input logic             tag_valid_o
);
  logic cb_q, hb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cb_q <= 1'b0;
      hb_q <= 1'b0;
    end else begin
      if (cipher_start_o)      cb_q <= 1'b1;
      else if (cipher_ready_i) cb_q <= 1'b0;
      if (hash_start_o)        hb_q <= 1'b1;
      else if (hash_ready_i)   hb_q <= 1'b0;
    end
  end

  // R6
  cipher_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cipher_start_o |-> (!cb_q || cipher_ready_i));
  // R11
  hash_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_start_o |-> (!hb_q || hash_ready_i));
  // R4
  ct_to_hash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ct_valid_o |-> (hash_start_o && !hash_final_o && hash_data_o == ct_data_o));
  // R8
  final_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_final_o |-> (hash_start_o && hash_data_o == '0));
  // R9
  tag_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_valid_o |=> !tag_valid_o);
  // R10
  tag_reopen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_valid_o |-> msg_ready_o);
endmodule

bind etm_sched etm_sched_chk #(.BLK_W(BLK_W)) u_chk (
  .clk_i, .rst_ni, .msg_ready_o, .cipher_start_o, .cipher_ready_i,
  .hash_start_o, .hash_final_o, .hash_data_o, .hash_ready_i,
  .ct_valid_o, .ct_data_o, .tag_valid_o
);

// File: tb/etm_sched_tb_top.sv
`timescale 1ns/1ps
module tb_eng_model #(
  parameter int W    = 64,
  parameter int LAT  = 31,
  parameter bit HASH = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         final_i,
  input  logic [W-1:0] data_i,
  output logic         ready_o,
  output logic [W-1:0] result_o
);
  localparam logic [W-1:0] KEY  = W'(64'h5A3C_96E1_0F87_D24B);
  localparam logic [W-1:0] FINC = W'(64'h0123_4567_89AB_CDEF);
  logic         busy_q;
  int           cnt_q;
  logic [W-1:0] st_q, res_q;
  assign ready_o  = busy_q && (cnt_q == 0);
  assign result_o = res_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; cnt_q <= 0; st_q <= '0; res_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1; cnt_q <= LAT - 1;
      if (!HASH) res_q <= data_i ^ KEY;
      else if (final_i) begin res_q <= st_q ^ FINC; st_q <= '0; end
      else begin
        st_q  <= {st_q[W-2:0], st_q[W-1]} ^ data_i;
        res_q <= '0;
      end
    end else if (busy_q) begin
      if (cnt_q == 0) busy_q <= 1'b0;
      else cnt_q <= cnt_q - 1;
    end
  end
endmodule

module etm_sched_tb_top;
  localparam int W = 64;
  localparam int L = 16;
  localparam logic [W-1:0] KEY  = 64'h5A3C_96E1_0F87_D24B;
  localparam logic [W-1:0] FINC = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         msg_valid = 1'b0, msg_last = 1'b0;
  logic [W-1:0] msg_data = '0;
  logic         msg_ready, c_start, c_ready, h_start, h_final, h_ready, ct_valid, tag_valid;
  logic [W-1:0] c_data, c_res, h_data, h_res, ct_data, tag;
  logic [L-1:0] tag_len;

  etm_sched #(.BLK_W(W), .LEN_W(L)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .msg_ready_o(msg_ready),
    .msg_data_i(msg_data), .msg_last_i(msg_last), .cipher_start_o(c_start),
    .cipher_data_o(c_data), .cipher_ready_i(c_ready), .cipher_result_i(c_res),
    .hash_start_o(h_start), .hash_final_o(h_final), .hash_data_o(h_data),
    .hash_ready_i(h_ready), .hash_result_i(h_res), .ct_valid_o(ct_valid),
    .ct_data_o(ct_data), .tag_valid_o(tag_valid), .tag_o(tag), .tag_len_o(tag_len)
  );

  tb_eng_model #(.W(W), .LAT(31), .HASH(1'b0)) u_cip (
    .clk_i(clk), .rst_ni(rst_n), .start_i(c_start), .final_i(1'b0),
    .data_i(c_data), .ready_o(c_ready), .result_o(c_res));
  tb_eng_model #(.W(W), .LAT(18), .HASH(1'b1)) u_hsh (
    .clk_i(clk), .rst_ni(rst_n), .start_i(h_start), .final_i(h_final),
    .data_i(h_data), .ready_o(h_ready), .result_o(h_res));

  int checks = 0, errors = 0, cyc = 0;
  int acc_n, ct_n, st_n, fin_n, tag_n, tag_cyc, fin_cyc, bad_start;
  int acc_cyc [16];
  int ct_cyc  [16];
  logic [W-1:0] acc_d [16];
  logic [W-1:0] ct_d  [16];
  logic [W-1:0] tag_v;
  logic [L-1:0] tag_l;
  logic         rdy_at_tag;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (msg_valid && msg_ready && acc_n < 16) begin
      acc_cyc[acc_n] = cyc; acc_d[acc_n] = msg_data; acc_n++;
    end
    if (c_start) begin
      st_n++;
      if (c_data != msg_data) bad_start++;
    end
    if (ct_valid && ct_n < 16) begin ct_cyc[ct_n] = cyc; ct_d[ct_n] = ct_data; ct_n++; end
    if (h_start && h_final) begin fin_n++; fin_cyc = cyc; end
    if (tag_valid) begin tag_n++; tag_cyc = cyc; tag_v = tag; tag_l = tag_len; rdy_at_tag = msg_ready; end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    acc_n = 0; ct_n = 0; st_n = 0; fin_n = 0; tag_n = 0; bad_start = 0;
  endtask

  // drive n blocks; gap idle cycles after each; junk=1 offers junk while not ready
  task automatic send(input int n, input int gap, input logic [W-1:0] base, input bit junk);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      msg_valid = 1'b1; msg_data = base + W'(i * 64'h1111_0000_0101); msg_last = (i == n - 1);
      while (!msg_ready) @(negedge clk);
      @(negedge clk);
      msg_valid = 1'b0; msg_last = 1'b0;
      if (junk) begin
        for (int k = 0; k < 10; k++) begin
          msg_valid = 1'b1; msg_data = ~base; msg_last = 1'b1;
          chk(!msg_ready, "R2 ready low while busy", 64'(msg_ready), 64'd0);
          @(negedge clk);
        end
        msg_valid = 1'b0; msg_last = 1'b0;
      end
      for (int k = 0; k < gap; k++) @(negedge clk);
    end
  endtask

  task automatic verify(input int n, input bit b2b, input string tname);
    logic [W-1:0] st;
    int waitc;
    waitc = 0;
    while (tag_n == 0 && waitc < 5000) begin @(negedge clk); waitc++; end
    repeat (3) @(negedge clk);
    chk(st_n == n && acc_n == n, {"R2 starts ", tname}, 64'(st_n), 64'(n));
    chk(bad_start == 0, {"R2 cipher data ", tname}, 64'(bad_start), 64'd0);
    chk(ct_n == n, {"R7 ct count ", tname}, 64'(ct_n), 64'(n));
    st = '0;
    for (int i = 0; i < n && i < ct_n; i++) begin
      chk(ct_d[i] == (acc_d[i] ^ KEY), {"R3 ct data ", tname}, ct_d[i], acc_d[i] ^ KEY);
      chk(ct_cyc[i] - acc_cyc[i] == 31, {"R3 ct latency ", tname}, 64'(ct_cyc[i] - acc_cyc[i]), 64'd31);
      if (b2b && i > 0)
        chk(acc_cyc[i] - acc_cyc[i-1] == 31, {"R5 spacing ", tname}, 64'(acc_cyc[i] - acc_cyc[i-1]), 64'd31);
      st = {st[W-2:0], st[W-1]} ^ (acc_d[i] ^ KEY);
    end
    chk(fin_n == 1 && fin_cyc - acc_cyc[n-1] == 49, {"R8 final start ", tname}, 64'(fin_cyc - acc_cyc[n-1]), 64'd49);
    chk(tag_n == 1, {"R9 tag count ", tname}, 64'(tag_n), 64'd1);
    chk(tag_cyc - acc_cyc[n-1] == 68, {"R9 tag latency ", tname}, 64'(tag_cyc - acc_cyc[n-1]), 64'd68);
    chk(tag_v == (st ^ FINC), {"R9 tag value ", tname}, tag_v, st ^ FINC);
    chk(rdy_at_tag, {"R10 ready at tag ", tname}, 64'(rdy_at_tag), 64'd1);
    chk(tag_l == L'(n), {"R12 length ", tname}, 64'(tag_l), 64'(n));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(msg_ready == 1'b1, "R1 ready", 64'(msg_ready), 64'd1);
    chk({c_start, h_start, ct_valid, tag_valid} == 4'b0, "R1 strobes",
        64'({c_start, h_start, ct_valid, tag_valid}), 64'd0);
  endtask

  task automatic t_single();
    clear_log(); send(1, 0, 64'hDEAD_BEEF_0000_0001, 1'b0); verify(1, 1'b0, "single");
  endtask

  task automatic t_stream();
    clear_log(); send(4, 0, 64'h1234_5678_9ABC_DEF0, 1'b0); verify(4, 1'b1, "b2b");
  endtask

  task automatic t_gaps();
    clear_log(); send(3, 7, 64'h0F0F_0000_FFFF_0001, 1'b0); verify(3, 1'b0, "gaps");
  endtask

  task automatic t_ignore();
    int hold;
    clear_log(); send(2, 0, 64'hCAFE_0000_1234_5678, 1'b1);
    // offer junk after last accepted, before tag (R10)
    hold = 0;
    msg_valid = 1'b1; msg_data = '1; msg_last = 1'b0;
    while (tag_n == 0 && hold < 200) begin
      chk(!msg_ready || tag_valid, "R10 closed until tag", 64'(msg_ready), 64'd0);
      @(negedge clk); hold++;
      if (tag_valid) begin msg_valid = 1'b0; end
    end
    msg_valid = 1'b0;
    verify(2, 1'b0, "ignore");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_stream();
    t_gaps();
    t_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule